// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block runs clean and invalidate maintenance on a cache, either on one line or across a run of consecutive lines. A requester sends register-style writes. Each write carries a 3-bit operation code and a 32-bit address. To start a range operation, the requester first writes the lower bound. It then writes the upper bound, and the opcode of that second write selects clean or invalidate. The second write launches the walk. The engine visits, in ascending order, every 32-byte line whose first byte lies inside the inclusive bound pair. For each line it issues one request to the tag/data array and waits for that request's acknowledge.

Both bounds must fall in the same 4 KB page. Because of this, only the lower bound ever needs an address translation. The engine rejects a pair that crosses a page or is reversed and raises an error flag. While any operation is in flight, `stall_o` holds the requester off. The single-line commands (clean, clean+invalidate, invalidate) and the whole-cache invalidate each produce exactly one array request.

Top module: `cache_range_maint`

## Requirements
- R1: While reset is asserted and right after it, `stall_o`, `arr_req_o` and `err_o` are low.
- R2: Operation code 0 with `wr_valid_i` high stores `wr_data_i` as the range lower bound. It causes no array request and no stall.
- R3: Operation code 1 (range clean, array command 0) or 2 (range invalidate, array command 2) sets the upper bound and starts a walk. The walk requests every line address `L` (a multiple of 32) with lower bound ≤ `L` ≤ upper bound, in ascending steps of 32.
- R4: Each array request keeps `arr_addr_o` and `arr_cmd_o` stable until the cycle in which `arr_ack_i` is high. The next line is presented in the following cycle.
- R5: `stall_o` rises in the cycle after a launching write and falls in the cycle after the final acknowledge. `arr_req_o` is high only while `stall_o` is high.
- R6: A range launch whose bounds differ in address bits [31:12] issues no request and no stall, and sets `err_o`.
- R7: A range launch whose upper bound is numerically below its lower bound issues no request and no stall, and sets `err_o`.
- R8: A valid in-page range that contains no line start (for example 0x21..0x3F) completes at once, with no request and no stall, and leaves `err_o` low.
- R9: Operation codes 3, 4 and 5 issue one request to the line containing `wr_data_i` (the address with its low 5 bits cleared), using array commands 0 (clean), 1 (clean+invalidate) and 2 (invalidate) respectively.
- R10: Operation code 6 issues one request with array command 3 and address 0.
- R11: Writes arriving while `stall_o` is high are ignored, including writes of the lower bound. Operation code 7 is always ignored.
- R12: `err_o` changes only on an accepted write with operation code 1 to 6. It is set by a rejected range and cleared by any other such write. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Command write strobe |
| wr_op_i | input | 3 | Operation code |
| wr_data_i | input | 32 | Address operand |
| stall_o | output | 1 | Requester hold while an operation runs |
| err_o | output | 1 | Last range launch was rejected |
| arr_req_o | output | 1 | Array request valid |
| arr_cmd_o | output | 2 | Array command: 0 clean, 1 clean+inv, 2 inv, 3 inv-all |
| arr_addr_o | output | 32 | Line address of the request |
| arr_ack_i | input | 1 | Array acknowledge for the current request |

## Verification
A wrong line counter shows up at the array port within one acknowledge. The bench catches it as a skipped or repeated line address, or as a walk that ends early or runs past the upper bound. A stale busy state or a corrupted lower-bound register shows on `stall_o` in the cycle after the launching write, or in the address of the first request. The bench drives every walk with acknowledge delays of zero, one and two cycles. It compares each presented address in every cycle against an arithmetic model. This means a hold or step fault becomes visible in the cycle it occurs.

// File: rtl/cache_maint_pkg.sv
package cache_maint_pkg;
  typedef enum logic [2:0] {
    OP_SET_START  = 3'd0,
    OP_END_CLEAN  = 3'd1,
    OP_END_INV    = 3'd2,
    OP_LINE_CLEAN = 3'd3,
    OP_LINE_CLINV = 3'd4,
    OP_LINE_INV   = 3'd5,
    OP_INV_ALL    = 3'd6,
    OP_NONE       = 3'd7
  } maint_op_e;

  typedef enum logic [1:0] {
    ARR_CLEAN   = 2'd0,
    ARR_CLINV   = 2'd1,
    ARR_INV     = 2'd2,
    ARR_INV_ALL = 2'd3
  } arr_cmd_e;
endpackage

// File: rtl/cmr_range_check.sv
module cmr_range_check #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int PAGE_OFF = 12,
  localparam int IDX_W   = ADDR_W - LINE_OFF
) (
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  output logic              same_page_o,
  output logic              ordered_o,
  output logic              nonempty_o,
  output logic [IDX_W-1:0]  first_idx_o,
  output logic [IDX_W-1:0]  last_idx_o
);
  localparam logic [ADDR_W:0] LINE_MASK = (ADDR_W+1)'((1 << LINE_OFF) - 1);

  logic [ADDR_W:0] lo_up;
  logic [IDX_W:0]  first_ext;

  // round lower bound up to the next line start; extra bit catches wrap
  assign lo_up       = {1'b0, lo_addr_i} + LINE_MASK;
  assign first_ext   = lo_up[ADDR_W:LINE_OFF];
  assign first_idx_o = first_ext[IDX_W-1:0];
  assign last_idx_o  = hi_addr_i[ADDR_W-1:LINE_OFF];
  assign same_page_o = lo_addr_i[ADDR_W-1:PAGE_OFF] == hi_addr_i[ADDR_W-1:PAGE_OFF];
  assign ordered_o   = hi_addr_i >= lo_addr_i;
  assign nonempty_o  = first_ext <= {1'b0, last_idx_o};
endmodule

// File: rtl/cmr_cmd_ctrl.sv
module cmr_cmd_ctrl
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int PAGE_OFF = 12,
  localparam int IDX_W   = ADDR_W - LINE_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [2:0]        wr_op_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              launch_o,
  output arr_cmd_e          launch_cmd_o,
  output logic [IDX_W-1:0]  first_idx_o,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] lo_q;
  logic              err_q;
  logic              accept;
  maint_op_e         op;
  logic              same_page, ordered, nonempty;
  logic [IDX_W-1:0]  rc_first, rc_last;
  logic              launch_c, err_upd, err_set;

  assign op     = maint_op_e'(wr_op_i);
  assign accept = wr_valid_i && !busy_i;

  cmr_range_check #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .PAGE_OFF(PAGE_OFF)
  ) u_rc (
    .lo_addr_i  (lo_q),
    .hi_addr_i  (wr_data_i),
    .same_page_o(same_page),
    .ordered_o  (ordered),
    .nonempty_o (nonempty),
    .first_idx_o(rc_first),
    .last_idx_o (rc_last)
  );

  always_comb begin
    launch_c     = 1'b0;
    err_upd      = 1'b0;
    err_set      = 1'b0;
    launch_cmd_o = ARR_CLEAN;
    first_idx_o  = wr_data_i[ADDR_W-1:LINE_OFF];
    last_idx_o   = wr_data_i[ADDR_W-1:LINE_OFF];
    unique case (op)
      OP_END_CLEAN, OP_END_INV: begin
        err_upd      = 1'b1;
        launch_cmd_o = (op == OP_END_CLEAN) ? ARR_CLEAN : ARR_INV;
        first_idx_o  = rc_first;
        last_idx_o   = rc_last;
        if (!same_page || !ordered) err_set = 1'b1;
        else                        launch_c = nonempty;
      end
      OP_LINE_CLEAN: begin launch_c = 1'b1; err_upd = 1'b1; launch_cmd_o = ARR_CLEAN; end
      OP_LINE_CLINV: begin launch_c = 1'b1; err_upd = 1'b1; launch_cmd_o = ARR_CLINV; end
      OP_LINE_INV:   begin launch_c = 1'b1; err_upd = 1'b1; launch_cmd_o = ARR_INV;   end
      OP_INV_ALL: begin
        launch_c     = 1'b1;
        err_upd      = 1'b1;
        launch_cmd_o = ARR_INV_ALL;
        first_idx_o  = '0;
        last_idx_o   = '0;
      end
      default: ;
    endcase
  end

  assign launch_o = accept && launch_c;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      if (op == OP_SET_START) lo_q  <= wr_data_i;
      if (err_upd)            err_q <= err_set;
    end
  end
endmodule

// File: rtl/cmr_line_walker.sv
module cmr_line_walker
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  localparam int IDX_W   = ADDR_W - LINE_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  arr_cmd_e          cmd_i,
  input  logic [IDX_W-1:0]  first_i,
  input  logic [IDX_W-1:0]  last_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              req_o,
  output arr_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             busy_q;
  logic [IDX_W-1:0] cur_q, last_q;
  arr_cmd_e         cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      cmd_q  <= ARR_CLEAN;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cur_q  <= first_i;
      last_q <= last_i;
      cmd_q  <= cmd_i;
    end else if (busy_q && ack_i) begin
      if (cur_q == last_q) busy_q <= 1'b0;
      else                 cur_q  <= cur_q + IDX_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign req_o  = busy_q;
  assign cmd_o  = cmd_q;
  assign addr_o = {cur_q, {LINE_OFF{1'b0}}};
endmodule

// File: rtl/cache_range_maint.sv
module cache_range_maint
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [2:0]        wr_op_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              stall_o,
  output logic              err_o,
  output logic              arr_req_o,
  output logic [1:0]        arr_cmd_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic              arr_ack_i
);
  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int PAGE_OFF = $clog2(PAGE_BYTES);
  localparam int IDX_W    = ADDR_W - LINE_OFF;

  logic             busy, launch;
  arr_cmd_e         launch_cmd, walk_cmd;
  logic [IDX_W-1:0] first_idx, last_idx;

  cmr_cmd_ctrl #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .PAGE_OFF(PAGE_OFF)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_op_i     (wr_op_i),
    .wr_data_i   (wr_data_i),
    .busy_i      (busy),
    .launch_o    (launch),
    .launch_cmd_o(launch_cmd),
    .first_idx_o (first_idx),
    .last_idx_o  (last_idx),
    .err_o       (err_o)
  );

  cmr_line_walker #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)
  ) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .cmd_i   (launch_cmd),
    .first_i (first_idx),
    .last_i  (last_idx),
    .ack_i   (arr_ack_i),
    .busy_o  (busy),
    .req_o   (arr_req_o),
    .cmd_o   (walk_cmd),
    .addr_o  (arr_addr_o)
  );

  assign stall_o   = busy;
  assign arr_cmd_o = walk_cmd;
endmodule

// File: rtl/cmr_checker.sv
module cmr_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [2:0]        wr_op_i,
  input logic              stall_o,
  input logic              err_o,
  input logic              arr_req_o,
  input logic [1:0]        arr_cmd_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              arr_ack_i
);
  localparam int PAGE_OFF = $clog2(PAGE_BYTES);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && !arr_ack_i) |=> (arr_req_o && $stable(arr_addr_o) && $stable(arr_cmd_o))); // R4

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && arr_ack_i && !(wr_valid_i && wr_op_i == 3'd6)) |=>
      (!arr_req_o || (arr_addr_o == $past(arr_addr_o) + ADDR_W'(LINE_BYTES)))); // R3

  AST_WALK_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && arr_ack_i) |=>
      (!arr_req_o || (arr_addr_o[ADDR_W-1:PAGE_OFF] == $past(arr_addr_o[ADDR_W-1:PAGE_OFF])))); // R6

  AST_ERR_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(err_o)); // R12

  AST_ERR_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !stall_o); // R7

  AST_INV_ALL_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !stall_o && wr_op_i == 3'd6) |=>
      (stall_o && arr_req_o && arr_cmd_o == 2'd3 && arr_addr_o == '0)); // R10

  AST_REQ_ONLY_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |-> stall_o); // R5
endmodule

bind cache_range_maint cmr_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_op_i   (wr_op_i),
  .stall_o   (stall_o),
  .err_o     (err_o),
  .arr_req_o (arr_req_o),
  .arr_cmd_o (arr_cmd_o),
  .arr_addr_o(arr_addr_o),
  .arr_ack_i (arr_ack_i)
);

// File: tb/cache_range_maint_test.sv
module cache_range_maint_test;
  localparam longint PG = 64'h0004_5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0;
  logic [2:0]  wop = 3'd7;
  logic [31:0] wd = '0;
  logic        stall, err, req, ack = 1'b0;
  logic [1:0]  cmd;
  logic [31:0] addr;
  int          vectors = 0;
  int          miscompares = 0;
  int          ack_rot = 0;

  always #5 clk = ~clk;

  cache_range_maint uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_op_i(wop), .wr_data_i(wd),
    .stall_o(stall), .err_o(err), .arr_req_o(req), .arr_cmd_o(cmd),
    .arr_addr_o(addr), .arr_ack_i(ack)
  );

  task automatic chk(bit ok, string rq, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic wr(logic [2:0] op, logic [31:0] d);
    @(negedge clk); wv = 1'b1; wop = op; wd = d;
    @(negedge clk); wv = 1'b0; wop = 3'd7;
  endtask

  // acts as the array: checks each presented line, acks after 0..2 idle cycles
  task automatic serve(longint first, int n, logic [1:0] c, string rq);
    for (int k = 0; k < n; k++) begin
      longint exp = first + 64'(k) * 32;
      int dly = ack_rot % 3;
      ack_rot++;
      for (int w = 0; w < dly; w++) begin
        chk(req && stall && addr == 32'(exp) && cmd == c, "R4", {31'd0, req, addr}, exp);
        @(negedge clk);
      end
      chk(req && stall && addr == 32'(exp) && cmd == c, rq, {30'd0, cmd, addr}, {30'd0, c, 32'(exp)});
      ack = 1'b1; @(negedge clk); ack = 1'b0;
    end
    chk(!stall && !req, "R5", {stall, req}, 0);
  endtask

  task automatic quiet(string rq, bit exp_err);
    for (int w = 0; w < 2; w++) begin
      chk(!stall && !req && err == exp_err, rq, {stall, req, err}, {2'b00, exp_err});
      @(negedge clk);
    end
  endtask

  task automatic do_range(longint s, longint e, bit inv);
    longint first, last;
    wr(3'd0, 32'(s));
    wr(inv ? 3'd2 : 3'd1, 32'(e));
    first = (s + 31) & ~64'd31;
    last  = e & ~64'd31;
    if ((s >> 12) != (e >> 12)) quiet("R6", 1'b1);
    else if (e < s) quiet("R7", 1'b1);
    else if (first > last) quiet("R8", 1'b0);
    else begin
      chk(stall == 1'b1, "R5", stall, 1);
      serve(first, int'((last - first) / 32) + 1, inv ? 2'd2 : 2'd0, "R3");
      chk(err == 1'b0, "R12", err, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!stall && !req && !err, "R1", {stall, req, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !req && !err, "R1", {stall, req, err}, 0);

    // R2: lower bound write alone does nothing visible
    wr(3'd0, 32'(PG + 64'h40));
    quiet("R2", 1'b0);

    // R3/R6/R7/R8: sweep bound offsets over one page
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 10; j++)
        do_range(PG + 64'(i * 389), PG + 64'(j * 433), 1'((i + j) % 2));
    do_range(PG, PG + 64'hFFF, 1'b0);
    do_range(PG + 64'h21, PG + 64'h3F, 1'b1);
    do_range(PG + 64'h20, PG + 64'h20, 1'b1);
    do_range(64'hFFFF_FFE1, 64'hFFFF_FFFF, 1'b0);
    do_range(64'hFFFF_FFC0, 64'hFFFF_FFFF, 1'b1);
    do_range(PG + 64'hF00, PG + 64'h1010, 1'b0);

    // R12: lower bound write keeps error, line op clears it
    wr(3'd0, 32'(PG + 64'h80));
    chk(err == 1'b1, "R12", err, 1);
    wr(3'd3, 32'(PG + 64'h47));
    serve(PG + 64'h40, 1, 2'd0, "R9");
    chk(err == 1'b0, "R12", err, 0);
    wr(3'd4, 32'(PG + 64'h9FF));
    serve(PG + 64'h9E0, 1, 2'd1, "R9");
    wr(3'd5, 32'(PG + 64'h100));
    serve(PG + 64'h100, 1, 2'd2, "R9");
    wr(3'd6, 32'hDEAD_BEEF);
    serve(0, 1, 2'd3, "R10");

    // R11: writes during a walk are ignored
    wr(3'd0, 32'(PG + 64'h100));
    wr(3'd1, 32'(PG + 64'h17F));
    wv = 1'b1; wop = 3'd0; wd = 32'(PG + 64'h800);
    @(negedge clk); wop = 3'd6;
    @(negedge clk); wop = 3'd2; wd = 32'(PG);
    @(negedge clk); wv = 1'b0; wop = 3'd7;
    ack_rot = 0;
    serve(PG + 64'h100, 4, 2'd0, "R11");
    wr(3'd2, 32'(PG + 64'h13F));
    serve(PG + 64'h100, 2, 2'd2, "R11");
    wr(3'd7, 32'(PG + 64'h500));
    quiet("R11", 1'b0);
    wr(3'd2, 32'(PG + 64'h13F));
    serve(PG + 64'h100, 2, 2'd2, "R11");

    finish_run();
  end
endmodule